// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is a single output cell of a small programmable logic device. It takes a sum-of-products data term from the logic array and produces the cell output and its output-enable. A set of static configuration inputs decides how the value is produced. The value can pass straight through (combinational), or it can be held in one storage element. That element can act as a D flip-flop, a toggle flip-flop, a transparent latch or a register that captures on both clock edges.

The clock for the storage element is picked per cell from three global clocks or a product-term clock, with a selectable active phase. The cell fabric runs on a fast sampling clock `clk`. An edge of the selected cell clock is a change in its phase-adjusted value between two consecutive `clk` samples. The global set/reset and the local set and reset take effect on the output in the same cycle they are asserted, and then settle the stored bit at the next `clk` edge. A one-cycle `init` pulse stands in for power-up and loads the configured start value.

Top module: `macrocell_reg`

## Requirements
- R1: With `cfg_mode`=1 (D flip-flop), an enabled active edge makes the stored value equal to the data input sampled on that edge.
- R2: With `cfg_mode`=2 (toggle), an enabled active edge inverts the stored value when the data input is 1 and keeps it when the data input is 0.
- R3: With `cfg_mode`=3 (latch), the output follows the data input while the phase-adjusted clock is 1 and `ce` is 1. Otherwise it holds the last value passed.
- R4: With `cfg_mode`=0 (combinational), `cell_out` equals `pt_data` in the same cycle, and the set, reset and clock inputs have no effect on it.
- R5: With `cfg_mode`=4 (dual edge), enabled rising and falling transitions of the phase-adjusted clock both capture the data input.
- R6: `cfg_clk_sel` picks the cell clock: 0, 1 and 2 select `gclk[0]`, `gclk[1]` and `gclk[2]`, and 3 selects `pt_clk`. With `cfg_clk_inv`=1 the active edge is the falling edge of the selected clock.
- R7: When `gsr` is 1 and `cfg_gsr_en` is 1, the cell is forced to `cfg_gsr_val`. With `cfg_gsr_en`=0, `gsr` has no effect.
- R8: `lrst` forces 0 and `lset` forces 1. Reset wins when both are active. The forced value shows on `cell_out` in the same cycle and overrides clock and `ce`.
- R9: A cycle with `init`=1 loads `cfg_init_val` into the storage element.
- R10: With `ce`=0, active edges leave the stored value unchanged in the flip-flop modes and keep the latch closed.
- R11: With `cfg_direct`=1, the registered modes take their data from `pin_in` instead of `pt_data`.
- R12: `cfg_oe_sel` picks `cell_oe`: 0 gives `pt_oe`, 1 gives `goe`, 2 gives constant 1 and 3 gives constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric sampling clock |
| init | input | 1 | Power-up load pulse |
| cfg_mode | input | 3 | 0 comb, 1 D, 2 toggle, 3 latch, 4 dual edge (5-7 act as D) |
| cfg_clk_sel | input | 2 | Cell clock source select |
| cfg_clk_inv | input | 1 | Invert cell clock phase |
| cfg_gsr_en | input | 1 | Cell responds to global set/reset |
| cfg_gsr_val | input | 1 | Value forced by global set/reset |
| cfg_init_val | input | 1 | Power-up value |
| cfg_direct | input | 1 | Load from pin input |
| cfg_oe_sel | input | 2 | Output-enable source select |
| pt_data | input | 1 | Sum-of-products data term |
| pin_in | input | 1 | Direct pin input |
| gclk | input | 3 | Global clocks |
| pt_clk | input | 1 | Product-term clock |
| ce | input | 1 | Synchronous clock enable |
| gsr | input | 1 | Global set/reset |
| lset | input | 1 | Local asynchronous set |
| lrst | input | 1 | Local asynchronous reset |
| pt_oe | input | 1 | Product-term output enable |
| goe | input | 1 | Global output enable |
| cell_out | output | 1 | Cell output |
| cell_oe | output | 1 | Cell output enable |

## Verification
Every cycle, the assertions check the edge behaviour of the storage element. This covers capture in D mode, inversion in toggle mode, holding with the enable low, clearing and setting under the local and global controls, and the constant output-enable codes. Some behaviour only the bench's scenarios can show. This includes that reset wins over set at the output, that a latch passes data while open, that dual-edge capture happens on both transitions, that each clock-select code and polarity reaches the register, and that the init value is seen after the pulse. The bench shows these by comparing against its own model over random configurations and input streams.

// File: rtl/macrocell_reg.sv
module macrocell_reg (
  input  logic       clk,
  input  logic       init,
  input  logic [2:0] cfg_mode,
  input  logic [1:0] cfg_clk_sel,
  input  logic       cfg_clk_inv,
  input  logic       cfg_gsr_en,
  input  logic       cfg_gsr_val,
  input  logic       cfg_init_val,
  input  logic       cfg_direct,
  input  logic [1:0] cfg_oe_sel,
  input  logic       pt_data,
  input  logic       pin_in,
  input  logic [2:0] gclk,
  input  logic       pt_clk,
  input  logic       ce,
  input  logic       gsr,
  input  logic       lset,
  input  logic       lrst,
  input  logic       pt_oe,
  input  logic       goe,
  output logic       cell_out,
  output logic       cell_oe
);
  localparam logic [2:0] M_COMB  = 3'd0;
  localparam logic [2:0] M_DFF   = 3'd1;
  localparam logic [2:0] M_TFF   = 3'd2;
  localparam logic [2:0] M_LATCH = 3'd3;
  localparam logic [2:0] M_DUAL  = 3'd4;

  logic sel_clk, phase, phase_q, q;
  logic rise, fall, d_in, rst_act, set_act, latch_open;

  always_comb begin
    case (cfg_clk_sel)
      2'd0:    sel_clk = gclk[0];
      2'd1:    sel_clk = gclk[1];
      2'd2:    sel_clk = gclk[2];
      default: sel_clk = pt_clk;
    endcase
  end

  assign phase      = sel_clk ^ cfg_clk_inv;
  assign rise       = phase & ~phase_q;
  assign fall       = ~phase & phase_q;
  assign d_in       = cfg_direct ? pin_in : pt_data;
  assign rst_act    = lrst | (gsr & cfg_gsr_en & ~cfg_gsr_val);
  assign set_act    = lset | (gsr & cfg_gsr_en & cfg_gsr_val);
  assign latch_open = (cfg_mode == M_LATCH) & phase & ce;

  always_ff @(posedge clk) begin
    phase_q <= phase;
    if (init)         q <= cfg_init_val;
    else if (rst_act) q <= 1'b0;
    else if (set_act) q <= 1'b1;
    else begin
      case (cfg_mode)
        M_COMB:  q <= q;
        M_TFF:   if (rise && ce && d_in) q <= ~q;
        M_LATCH: if (phase && ce) q <= d_in;
        M_DUAL:  if ((rise || fall) && ce) q <= d_in;
        default: if (rise && ce) q <= d_in;
      endcase
    end
  end

  always_comb begin
    if (cfg_mode == M_COMB) cell_out = pt_data;
    else if (rst_act)       cell_out = 1'b0;
    else if (set_act)       cell_out = 1'b1;
    else if (latch_open)    cell_out = d_in;
    else                    cell_out = q;
  end

  always_comb begin
    case (cfg_oe_sel)
      2'd0:    cell_oe = pt_oe;
      2'd1:    cell_oe = goe;
      2'd2:    cell_oe = 1'b1;
      default: cell_oe = 1'b0;
    endcase
  end

  AST_DFF_CAPTURE: assert property (@(posedge clk) disable iff (init)
    (cfg_mode == M_DFF && rise && ce && !rst_act && !set_act) |=> q == $past(d_in)); // R1
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (init)
    (cfg_mode == M_TFF && rise && ce && d_in && !rst_act && !set_act) |=> q != $past(q)); // R2
  AST_CE_HOLD: assert property (@(posedge clk) disable iff (init)
    (cfg_mode != M_COMB && !ce && !rst_act && !set_act) |=> $stable(q)); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (init)
    rst_act |=> !q); // R8
  AST_GSR_SETS: assert property (@(posedge clk) disable iff (init)
    (gsr && cfg_gsr_en && cfg_gsr_val && !lrst) |=> q); // R7
  AST_OE_CONST: assert property (@(posedge clk) disable iff (init)
    (cfg_oe_sel[1]) |-> (cell_oe == ~cfg_oe_sel[0])); // R12
endmodule

// File: tb/macrocell_reg_bench.sv
module macrocell_reg_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic init = 1'b1;
  logic [2:0] cfg_mode = '0;
  logic [1:0] cfg_clk_sel = '0, cfg_oe_sel = '0;
  logic cfg_clk_inv = 0, cfg_gsr_en = 0, cfg_gsr_val = 0, cfg_init_val = 0, cfg_direct = 0;
  logic pt_data = 0, pin_in = 0, pt_clk = 0, ce = 0, gsr = 0, lset = 0, lrst = 0, pt_oe = 0, goe = 0;
  logic [2:0] gclk = '0;
  logic cell_out, cell_oe;

  int checks = 0, fails = 0;
  bit done = 0;
  bit mq = 0, mprev = 0;

  macrocell_reg u_macrocell_reg (
    .clk(clk), .init(init), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
    .cfg_clk_inv(cfg_clk_inv), .cfg_gsr_en(cfg_gsr_en), .cfg_gsr_val(cfg_gsr_val),
    .cfg_init_val(cfg_init_val), .cfg_direct(cfg_direct), .cfg_oe_sel(cfg_oe_sel),
    .pt_data(pt_data), .pin_in(pin_in), .gclk(gclk), .pt_clk(pt_clk), .ce(ce),
    .gsr(gsr), .lset(lset), .lrst(lrst), .pt_oe(pt_oe), .goe(goe),
    .cell_out(cell_out), .cell_oe(cell_oe));

  always #(PERIOD/2) clk = ~clk;

  function automatic bit m_phase();
    bit c;
    case (cfg_clk_sel)
      2'd0: c = gclk[0];
      2'd1: c = gclk[1];
      2'd2: c = gclk[2];
      default: c = pt_clk;
    endcase
    return c ^ cfg_clk_inv;
  endfunction

  function automatic bit m_data();
    return cfg_direct ? pin_in : pt_data;
  endfunction

  function automatic bit m_rst();
    return lrst || (gsr && cfg_gsr_en && !cfg_gsr_val);
  endfunction

  function automatic bit m_set();
    return lset || (gsr && cfg_gsr_en && cfg_gsr_val);
  endfunction

  function automatic bit m_out();
    if (cfg_mode == 3'd0) return pt_data;
    if (m_rst()) return 1'b0;
    if (m_set()) return 1'b1;
    if (cfg_mode == 3'd3 && m_phase() && ce) return m_data();
    return mq;
  endfunction

  function automatic bit m_oe();
    case (cfg_oe_sel)
      2'd0: return pt_oe;
      2'd1: return goe;
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_for();
    if (cfg_mode == 3'd0) return "R4";
    if (lrst || lset) return "R8";
    if (gsr) return "R7";
    if (!ce) return "R10";
    if (cfg_direct) return "R11";
    if (cfg_clk_sel != 2'd0 || cfg_clk_inv) return "R6";
    case (cfg_mode)
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit ph, r, f;
    ph = m_phase();
    r = ph && !mprev;
    f = !ph && mprev;
    if (init) mq = cfg_init_val;
    else if (m_rst()) mq = 1'b0;
    else if (m_set()) mq = 1'b1;
    else case (cfg_mode)
      3'd0: ;
      3'd2: if (r && ce && m_data()) mq = !mq;
      3'd3: if (ph && ce) mq = m_data();
      3'd4: if ((r || f) && ce) mq = m_data();
      default: if (r && ce) mq = m_data();
    endcase
    mprev = ph;
  endtask

  task automatic rand_inputs();
    pt_data = 1'($urandom); pin_in = 1'($urandom);
    gclk = 3'($urandom); pt_clk = 1'($urandom);
    ce = ($urandom % 4) != 0;
    gsr = ($urandom % 10) == 0;
    lset = ($urandom % 12) == 0;
    lrst = ($urandom % 12) == 0;
    pt_oe = 1'($urandom); goe = 1'($urandom);
  endtask

  task automatic quiet();
    gsr = 0; lset = 0; lrst = 0; ce = 0;
  endtask

  task automatic step_check(input string req);
    #1;
    if (!init) begin
      check(req, cell_out, m_out());
      check("R12", cell_oe, m_oe());
    end
    model_step();
  endtask

  task automatic do_init();
    @(negedge clk); init = 1; quiet(); step_check("R9");
    @(negedge clk); init = 0; quiet(); step_check("R9");
    if (cfg_mode != 3'd0) check("R9", cell_out, cfg_init_val);
  endtask

  task automatic set_cfg(input bit [2:0] m, input bit [1:0] cs, input bit inv, input bit gen,
                         input bit gval, input bit iv, input bit dir, input bit [1:0] oes);
    cfg_mode = m; cfg_clk_sel = cs; cfg_clk_inv = inv; cfg_gsr_en = gen;
    cfg_gsr_val = gval; cfg_init_val = iv; cfg_direct = dir; cfg_oe_sel = oes;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    set_cfg(3'd1, 2'd0, 0, 0, 0, 1, 0, 2'd2);
    @(negedge clk); step_check("R9");
    do_init();
    // R8: set and reset together, reset wins, no clock needed
    @(negedge clk); quiet(); lset = 1; lrst = 1; step_check("R8");
    check("R8", cell_out, 1'b0);
    // R7: global set/reset disabled has no effect
    set_cfg(3'd1, 2'd0, 0, 0, 1, 0, 0, 2'd3);
    do_init();
    @(negedge clk); quiet(); gsr = 1; step_check("R7");
    check("R7", cell_out, 1'b0);
    check("R12", cell_oe, 1'b0);
    // R4: combinational ignores reset
    set_cfg(3'd0, 2'd0, 0, 1, 0, 0, 0, 2'd2);
    do_init();
    @(negedge clk); quiet(); lrst = 1; pt_data = 1; step_check("R4");
    check("R4", cell_out, 1'b1);
    // R5: dual edge, falling edge captures
    set_cfg(3'd4, 2'd1, 0, 0, 0, 0, 0, 2'd2);
    do_init();
    @(negedge clk); quiet(); ce = 1; gclk = 3'b010; pt_data = 1; step_check("R5");
    @(negedge clk); gclk = 3'b000; pt_data = 0; step_check("R5");
    @(negedge clk); step_check("R5");
    check("R5", cell_out, 1'b0);

    for (int k = 0; k < 60; k++) begin
      set_cfg(3'($urandom % 5), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 2'($urandom));
      do_init();
      for (int i = 0; i < 120; i++) begin
        @(negedge clk);
        rand_inputs();
        step_check(tag_for());
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule